// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit sits between a CPU register interface and the handshake lines of a serial port. A control register drives four active-low output lines: data terminal ready, request to send, and two general-purpose outputs. A status register reports the asserted state of four active-low input lines: clear to send, data set ready, ring indicator and carrier detect. For each input line the status register also keeps a sticky change flag.

The CPU writes the control register with a one-cycle write strobe. It reads the status register with a one-cycle read strobe. The read clears every change flag, except a flag whose line changes in that same cycle. While the modem-status interrupt enable is high, any set change flag raises the interrupt request. A loop input holds all four output lines at their inactive high level and leaves the stored control value untouched. The input lines are asynchronous to the clock, so each one passes through a two-flop synchroniser before it is reported or compared.

Top module: `modem_ctl_stat`

## Requirements
- R1: A write strobe stores write data bits 3:0 in the control register at the clock edge. The control read data shows them in bits 3:0, with bits 7:4 at zero.
- R2: With loop low, each output line is the inverse of its control bit: bit 0 drives dtr_n, bit 1 drives rts_n, bit 2 drives out1_n and bit 3 drives out2_n.
- R3: While loop_en is high, all four output lines are high. The stored control value stays readable and unchanged.
- R4: While reset is asserted, the control register is 0, all change flags are 0, all outputs are high and irq is low.
- R5: Status bits 4, 5, 6 and 7 show the asserted state (pin low reads 1) of cts_n, dsr_n, ri_n and dcd_n. The state appears after the second clock edge that samples a pin change.
- R6: Status bits 0, 1 and 3 are set when cts_n, dsr_n or dcd_n changes in either direction. The flag appears one edge after the level change shows in bits 7:4. A flag is never set without such a change.
- R7: Status bit 2 is set only when ri_n goes from low to high, which is the end of a ring. A high-to-low change of ri_n leaves it clear.
- R8: irq is high exactly when msi_en is high and at least one change flag is set. With msi_en low, irq stays low and the flags are still kept.
- R9: A status read strobe clears all change flags at that clock edge, and irq falls with them.
- R10: When a line's change event falls in the same cycle as a status read, that line's flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register read data |
| stat_rd | input | 1 | Status register read strobe (clears flags) |
| stat_rdata | output | 8 | Status read data: flags in 3:0, line states in 7:4 |
| loop_en | input | 1 | Loop mode, holds all outputs inactive |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
Any wrong synchroniser or previous-level state shows in stat_rdata. It appears either as a line level in bits 7:4 at the wrong edge, or as a flag that is set or missing one edge after the level. A flag lost because it collided with a read shows as a clear bit in the very next cycle. If msi_en is high, irq drops in that same cycle. A corrupted control register shows at once on both ctl_rdata and the output lines whenever loop is low. Comparing every port on every clock therefore exposes each of these faults within one to three cycles of its cause.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NLINES = 4;
  localparam int CTL_W  = 4;
  // line index inside the status nibbles; status decoding depends on it
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // change events between two synchronised samples of the active-low pins
  function automatic logic [NLINES-1:0] line_events(input logic [NLINES-1:0] prev_n,
                                                    input logic [NLINES-1:0] cur_n);
    logic [NLINES-1:0] e;
    e = prev_n ^ cur_n;
    e[L_RI] = ~prev_n[L_RI] & cur_n[L_RI];
    return e;
  endfunction

  // sticky flags: a read clears, a coincident event wins
  function automatic logic [NLINES-1:0] flags_next(input logic [NLINES-1:0] flags,
                                                   input logic [NLINES-1:0] evt,
                                                   input logic clr);
    return (clr ? '0 : flags) | evt;
  endfunction
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RST_VAL;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mcs_ctl.sv
module mcs_ctl #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     loop_en,
  output logic [mcs_pkg::CTL_W-1:0] ctl_q,
  output logic [mcs_pkg::CTL_W-1:0] pins_n
);
  import mcs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata[CTL_W-1:0];
  end

  assign pins_n = loop_en ? '1 : ~ctl_q;

  // R1
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctl_q == $past(wdata[CTL_W-1:0]));

  // R3
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> pins_n == '1);

  // R3
  loop_keeps_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !wr) |=> $stable(ctl_q));
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [mcs_pkg::NLINES-1:0] cur_n,
  input  logic                       rd_clr,
  output logic [mcs_pkg::NLINES-1:0] flags,
  output logic [mcs_pkg::NLINES-1:0] evt
);
  import mcs_pkg::*;

  logic [NLINES-1:0] prev_n;

  assign evt = line_events(prev_n, cur_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= '1;
      flags  <= '0;
    end else begin
      prev_n <= cur_n;
      flags  <= flags_next(flags, evt, rd_clr);
    end
  end

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> flags == '0);

  // R10
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (flags & $past(evt)) == $past(evt));

  // R6
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags)) & ~$past(evt)) == '0);

  // R7
  ri_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && prev_n[L_RI] && !cur_n[L_RI]) |=> !flags[L_RI]);
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] stat_rdata,
  input  logic              loop_en,
  input  logic              msi_en,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);
  import mcs_pkg::*;

  localparam int PAD_W = DATA_W - 2*NLINES;
  localparam int CPAD_W = DATA_W - CTL_W;

  logic [NLINES-1:0] raw_n, sync_n, flags, evt;
  logic [CTL_W-1:0]  ctl_q, pins_n;

  assign raw_n = {dcd_n, ri_n, dsr_n, cts_n};

  mcs_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n));

  mcs_delta u_delta (
    .clk(clk), .rst_n(rst_n), .cur_n(sync_n), .rd_clr(stat_rd),
    .flags(flags), .evt(evt));

  mcs_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .loop_en(loop_en), .ctl_q(ctl_q), .pins_n(pins_n));

  assign {out2_n, out1_n, rts_n, dtr_n} = pins_n;
  assign ctl_rdata  = {{CPAD_W{1'b0}}, ctl_q};
  assign irq        = msi_en & (|flags);

  if (PAD_W > 0) begin : g_pad
    assign stat_rdata = {{PAD_W{1'b0}}, ~sync_n, flags};
  end else begin : g_nopad
    assign stat_rdata = {~sync_n, flags};
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == '0) |=> !irq);
endmodule

// File: tb/test_modem_ctl_stat.sv
`timescale 1ns/100ps
module test_modem_ctl_stat;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, stat_rd = 0, loop_en = 0, msi_en = 0;
  logic [7:0] ctl_wdata = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic [7:0] ctl_rdata, stat_rdata;
  logic dtr_n, rts_n, out1_n, out2_n, irq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, started = 0;

  always #2.5 clk = ~clk;

  modem_ctl_stat i_modem_ctl_stat (.*);

  // behavioural reference: pin samples per edge, flags, control value
  logic [3:0] h1 = 4'hF, h2 = 4'hF, h3 = 4'hF;
  logic [3:0] m_flags = 0, m_ctl = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 4'hF; h2 = 4'hF; h3 = 4'hF; m_flags = 0; m_ctl = 0;
    end else begin
      logic [3:0] ev;
      ev[0] = h2[0] != h3[0];
      ev[1] = h2[1] != h3[1];
      ev[3] = h2[3] != h3[3];
      ev[2] = (h3[2] == 1'b0) && (h2[2] == 1'b1);
      if (stat_rd) m_flags = 0;
      m_flags = m_flags | ev;
      if (ctl_wr) m_ctl = ctl_wdata[3:0];
      h3 = h2; h2 = h1; h1 = {dcd_n, ri_n, dsr_n, cts_n};
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && started && !done) begin
    logic [3:0] eo;
    eo = loop_en ? 4'hF : ~m_ctl;
    chk("R1 control readback", ctl_rdata, {4'h0, m_ctl});
    chk("R2 R3 output lines", {4'h0, out2_n, out1_n, rts_n, dtr_n}, {4'h0, eo});
    chk("R5 line states", {4'h0, stat_rdata[7:4]}, {4'h0, ~h2});
    chk("R6 R7 R9 R10 change flags", {4'h0, stat_rdata[3:0]}, {4'h0, m_flags});
    chk("R8 irq", {7'h0, irq}, {7'h0, msi_en & (|m_flags)});
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic wr(input logic [7:0] d);
    ctl_wr = 1; ctl_wdata = d; step(1); ctl_wr = 0;
  endtask
  task automatic rd();
    stat_rd = 1; step(1); stat_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lf;
    step(3);
    // R4 reset state
    chk("R4 reset ctl", ctl_rdata, 8'h00);
    chk("R4 reset outputs", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    chk("R4 reset flags", {4'h0, stat_rdata[3:0]}, 8'h00);
    chk("R4 reset irq", {7'h0, irq}, 8'h00);
    rst_n = 1; started = 1;
    step(2);
    // R1 R2 bit mapping
    wr(8'hF5); step(2);
    wr(8'h0A); step(2);
    // R3 loop forces inactive, value retained
    loop_en = 1; step(2); wr(8'h03); step(2); loop_en = 0; step(2);
    // R6 each line, both directions, with interrupt masked (R8)
    cts_n = 0; step(4); dsr_n = 0; step(4); dcd_n = 0; step(4);
    rd(); step(2);
    msi_en = 1;
    cts_n = 1; step(4); rd(); step(2);
    // R7 ring start does not flag, ring end does
    ri_n = 0; step(5); ri_n = 1; step(5); rd(); step(3);
    // R10 event coincides with read: change at t, read two edges later
    dsr_n = 1; step(2); rd(); step(3); rd(); step(2);
    dcd_n = 1; ri_n = 0; step(2); rd(); step(3);
    ri_n = 1; step(2); rd(); step(3);
    // mixed random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 0) {dcd_n, ri_n, dsr_n, cts_n} = lf[7:4];
      stat_rd = (lf[10:9] == 0);
      ctl_wr = (lf[13:11] == 0); ctl_wdata = lf[15:8];
      if (lf[5:3] == 7) loop_en = ~loop_en;
      if (lf[8:6] == 7) msi_en = ~msi_en;
      step(1);
    end
    stat_rd = 0; ctl_wr = 0;
    step(4);
    finish_run();
  end
endmodule